// File: doc/BRIEF.md
# Multi-Function GPIO Pin Selector

This block decides what a single bidirectional general-purpose pin does. A 3-bit function field picks one of eight roles for the pin. Two roles leave the pin as an input. The others drive the pin with a status flag (temperature good, auto-mute active, PLL locked), a constant level, or a copy of the PLL clock. An invert bit can flip whatever is driven. A 2-bit ratio field slows the PLL clock by one, two, three or four before it reaches the pin.

The pin also serves as an input. The value seen on the pin goes to two consumers. One is the serial control port, which uses it as an active-low chip select. The other is the output-switching logic, which uses it as a jack-sense line. When the control port runs in its three-wire mode, the pin becomes the chip-select input and the function field is ignored. The block is clocked by the PLL clock. The divider runs on both of its edges.

Top module: `gpio_pin_mux`

## Requirements
- R1: With three-wire mode off, function codes 010, 011 and 101 drive the pin with tempOk, autoMute and pllLock respectively, and pinOe is 1.
- R2: With three-wire mode off, code 110 drives a 0 level and code 111 drives a 1 level, both with pinOe at 1. These levels are before the invert bit is applied.
- R3: When polInv is 1, the driven value is the logical complement of the selected source. When polInv is 0, the selected source is driven unchanged.
- R4: Codes 000 and 001 (001 is reserved) make the pin an input: pinOe is 0 and pinOut is 0. With three-wire mode off and code 000, jackDet equals pinIn and is not affected by polInv. In every other case jackDet is 0.
- R5: When threeWire is 1, the pin is an input whatever the function code is: pinOe is 0, pinOut is 0 and jackDet is 0. In this mode csN equals pinIn. When threeWire is 0, csN is held at 1.
- R6: Code 100 drives the PLL clock divided by N = divSel + 1, so divSel values 00, 01, 10 and 11 give ratios of 1, 2, 3 and 4. The result has exactly one rising edge every N PLL cycles and is high for N of every 2N PLL half-periods. Ratio 1 passes the PLL clock through, high in its first half-period.
- R7: The divide-by-3 output has a 50% duty cycle. It is high for three of every six PLL half-periods, with the high phase ending on a falling PLL edge.
- R8: When divSel changes, the next rising PLL edge restarts the divider, and the divided clock (ratio 2 to 4) is high during the half-period that follows that edge.
- R9: While rstN is low, the divider output is 0. This means that with code 100, no inversion and a ratio above 1, pinOut is 0. With code 000, pinOe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pllClk | input | 1 | PLL clock; clocks the divider on both edges |
| rstN | input | 1 | Asynchronous active-low reset |
| funcSel | input | 3 | Pin function code |
| polInv | input | 1 | Invert the driven value when 1 |
| divSel | input | DIV_W | PLL clock ratio minus one |
| threeWire | input | 1 | Control port is in three-wire mode; forces chip-select input |
| tempOk | input | 1 | Temperature-good status flag |
| autoMute | input | 1 | Auto-mute active status flag |
| pllLock | input | 1 | PLL lock status flag |
| pinIn | input | 1 | Level sensed on the pin |
| pinOut | output | 1 | Value driven on the pin (0 when not driving) |
| pinOe | output | 1 | Pin output-driver enable |
| csN | output | 1 | Active-low chip select to the control port |
| jackDet | output | 1 | Raw jack-sense level to the output-switching logic |

## Verification
The bench uses the default DIV_W of 2, so all four clock ratios can be reached. This covers the odd ratio that needs the falling-edge stage as well as the pass-through ratio. With this small configuration, the bench can sweep every combination of function code, invert bit, mode flag, the three status flags and the sensed pin level. For each ratio, it samples the divided clock twice per PLL cycle and compares the high-sample count and the rising-edge count with N·K and K. It also steps through every ordered pair of distinct ratios to check that the divider restarts when the ratio changes.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

  typedef enum logic [2:0] {
    FN_INPUT = 3'b000,
    FN_RSVD  = 3'b001,
    FN_TEMP  = 3'b010,
    FN_MUTE  = 3'b011,
    FN_CLK   = 3'b100,
    FN_LOCK  = 3'b101,
    FN_LOW   = 3'b110,
    FN_HIGH  = 3'b111
  } pinFunc_e;

  typedef struct packed {
    pinFunc_e srcSel;   // source routed to the pin
    logic     driveEn;  // pin driver on
    logic     csSel;    // pin feeds chip select
    logic     jackSel;  // pin feeds jack sense
    logic     restart;  // ratio changed: restart divider
    logic     bypass;   // ratio of one
    logic     oddDiv;   // odd ratio above one
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
  import gpio_mux_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       funcSel,
  input  logic [DIV_W-1:0] divSel,
  input  logic             threeWire,
  output ctrlStrobe_t      strobe
);

  logic [DIV_W-1:0] divPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divPrev <= '0;
    else       divPrev <= divSel;
  end

  always_comb begin
    pinFunc_e fn;
    fn             = pinFunc_e'(funcSel);
    strobe.srcSel  = fn;
    strobe.driveEn = !threeWire && (fn != FN_INPUT) && (fn != FN_RSVD);
    strobe.csSel   = threeWire;
    strobe.jackSel = !threeWire && (fn == FN_INPUT);
    strobe.restart = (divSel != divPrev);
    strobe.bypass  = (divSel == '0);
    strobe.oddDiv  = (divSel != '0) && !divSel[0];
  end

endmodule

// File: rtl/gpio_mux_dpath.sv
module gpio_mux_dpath
  import gpio_mux_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [DIV_W-1:0] divSel,
  input  logic             polInv,
  input  logic             tempOk,
  input  logic             autoMute,
  input  logic             pllLock,
  input  logic             pinIn,
  output logic             pinOut,
  output logic             pinOe,
  output logic             csN,
  output logic             jackDet
);

  localparam int N_W = DIV_W + 1;

  logic [DIV_W-1:0] cnt, cntNext;
  logic [N_W-1:0]   hiLen;
  logic             posQ, negQ, divClk, srcVal;

  // floor(N/2) rising-edge cycles high; odd ratios add half a cycle via negQ
  assign hiLen   = ({1'b0, divSel} + N_W'(1)) >> 1;
  assign cntNext = (strobe.restart || (cnt == divSel)) ? '0 : cnt + DIV_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      posQ <= 1'b0;
    end else begin
      cnt  <= cntNext;
      posQ <= ({1'b0, cntNext} < hiLen);
    end
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) negQ <= 1'b0;
    else       negQ <= posQ;
  end

  always_comb begin
    if (strobe.bypass)      divClk = clk;
    else if (strobe.oddDiv) divClk = posQ | negQ;
    else                    divClk = posQ;
  end

  always_comb begin
    case (strobe.srcSel)
      FN_TEMP: srcVal = tempOk;
      FN_MUTE: srcVal = autoMute;
      FN_CLK:  srcVal = divClk;
      FN_LOCK: srcVal = pllLock;
      FN_HIGH: srcVal = 1'b1;
      default: srcVal = 1'b0;
    endcase
  end

  assign pinOe   = strobe.driveEn;
  assign pinOut  = strobe.driveEn & (srcVal ^ polInv);
  assign csN     = strobe.csSel ? pinIn : 1'b1;
  assign jackDet = strobe.jackSel & pinIn;

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_mux_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic             pllClk,
  input  logic             rstN,
  input  logic [2:0]       funcSel,
  input  logic             polInv,
  input  logic [DIV_W-1:0] divSel,
  input  logic             threeWire,
  input  logic             tempOk,
  input  logic             autoMute,
  input  logic             pllLock,
  input  logic             pinIn,
  output logic             pinOut,
  output logic             pinOe,
  output logic             csN,
  output logic             jackDet
);

  ctrlStrobe_t strobe;

  gpio_mux_ctrl #(.DIV_W(DIV_W)) i_ctrl (
    .clk(pllClk), .rstN(rstN), .funcSel(funcSel), .divSel(divSel),
    .threeWire(threeWire), .strobe(strobe)
  );

  gpio_mux_dpath #(.DIV_W(DIV_W)) i_dpath (
    .clk(pllClk), .rstN(rstN), .strobe(strobe), .divSel(divSel),
    .polInv(polInv), .tempOk(tempOk), .autoMute(autoMute),
    .pllLock(pllLock), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .csN(csN), .jackDet(jackDet)
  );

endmodule

// File: rtl/gpio_pin_mux_chk.sv
module gpio_pin_mux_chk #(
  parameter int DIV_W = 2
) (
  input logic             pllClk,
  input logic             rstN,
  input logic [2:0]       funcSel,
  input logic             polInv,
  input logic [DIV_W-1:0] divSel,
  input logic             threeWire,
  input logic             autoMute,
  input logic             pinIn,
  input logic             pinOut,
  input logic             pinOe,
  input logic             csN
);

  // R1
  mute_route_chk: assert property (@(posedge pllClk) disable iff (!rstN)
    (!threeWire && funcSel == 3'b011) |-> (pinOe && pinOut == (autoMute ^ polInv)));

  // R2
  const_level_chk: assert property (@(posedge pllClk) disable iff (!rstN)
    (!threeWire && funcSel[2:1] == 2'b11) |-> (pinOe && pinOut == (funcSel[0] ^ polInv)));

  // R4
  input_code_chk: assert property (@(posedge pllClk) disable iff (!rstN)
    (funcSel[2:1] == 2'b00) |-> (!pinOe && !pinOut));

  // R5
  three_wire_chk: assert property (@(posedge pllClk) disable iff (!rstN)
    threeWire |-> (!pinOe && csN == pinIn));

  // R8
  ratio_restart_chk: assert property (@(posedge pllClk) disable iff (!rstN)
    (divSel != $past(divSel)) |=>
      (!(funcSel == 3'b100 && !threeWire && !polInv && divSel != '0) || pinOut));

endmodule

bind gpio_pin_mux gpio_pin_mux_chk #(.DIV_W(DIV_W)) i_chk (
  .pllClk(pllClk), .rstN(rstN), .funcSel(funcSel), .polInv(polInv),
  .divSel(divSel), .threeWire(threeWire), .autoMute(autoMute),
  .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .csN(csN)
);

// File: tb/test_gpio_pin_mux.sv
module test_gpio_pin_mux;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 2;
  localparam int K = 3;

  logic pllClk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] funcSel = 3'b000;
  logic polInv = 1'b0;
  logic [DIV_W-1:0] divSel = '0;
  logic threeWire = 1'b0;
  logic tempOk = 1'b0, autoMute = 1'b0, pllLock = 1'b0, pinIn = 1'b0;
  logic pinOut, pinOe, csN, jackDet;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) pllClk = ~pllClk;

  gpio_pin_mux #(.DIV_W(DIV_W)) i_gpio_pin_mux (
    .pllClk(pllClk), .rstN(rstN), .funcSel(funcSel), .polInv(polInv),
    .divSel(divSel), .threeWire(threeWire), .tempOk(tempOk),
    .autoMute(autoMute), .pllLock(pllLock), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .csN(csN), .jackDet(jackDet)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (sel=%0d pol=%0d tw=%0d div=%0d)",
               req, act, exp, funcSel, polInv, threeWire, divSel);
    end
  endtask

  task automatic settle_drive();
    @(posedge pllClk);
    #3;
  endtask

  // sample divided clock twice per PLL cycle, compare duty and edge count
  task automatic measure_ratio(input int n, input logic pol);
    logic s [0:64];
    int hi, rises;
    settle_drive();
    funcSel = 3'b100; polInv = pol; threeWire = 1'b0; divSel = DIV_W'(n - 1);
    repeat (10) @(posedge pllClk);
    for (int i = 0; i <= 2*n*K; i += 2) begin
      @(posedge pllClk); #2; s[i] = pinOut;
      if (i + 1 <= 2*n*K) begin
        @(negedge pllClk); #2; s[i+1] = pinOut;
      end
    end
    hi = 0; rises = 0;
    for (int i = 0; i < 2*n*K; i++) begin
      if (s[i]) hi++;
      if (!s[i] && s[i+1]) rises++;
    end
    if (n == 3) begin
      chk("R7 high half-periods at ratio 3", hi, n*K);
      chk("R7 rises at ratio 3", rises, K);
    end else begin
      chk("R6 high half-periods", hi, n*K);
      chk("R6 rising edges", rises, K);
    end
    if (n == 1 && !pol) chk("R6 pass-through high in first half", s[0], 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) @(posedge pllClk);
    #4;
    chk("R9 oe in reset with code 000", pinOe, 0);
    chk("R9 out in reset with code 000", pinOut, 0);
    funcSel = 3'b100; divSel = 2'd1;
    repeat (2) @(posedge pllClk);
    #4;
    chk("R9 divider held low in reset", pinOut, 0);
    @(negedge pllClk); #2;
    chk("R9 divider low in second half", pinOut, 0);
    settle_drive();
    rstN = 1'b1;
    funcSel = 3'b000; divSel = '0;

    // R1 R2 R3 R4 R5: exhaustive static sweep
    for (int sel = 0; sel < 8; sel++)
      for (int tw = 0; tw < 2; tw++)
        for (int pol = 0; pol < 2; pol++)
          for (int v = 0; v < 16; v++) begin
            int src, expOe, expOut;
            @(negedge pllClk);
            funcSel = 3'(sel); threeWire = tw[0]; polInv = pol[0];
            tempOk = v[0]; autoMute = v[1]; pllLock = v[2]; pinIn = v[3];
            #1;
            expOe = (tw == 0 && sel >= 2) ? 1 : 0;
            case (sel)
              2: src = v[0];
              3: src = v[1];
              5: src = v[2];
              7: src = 1;
              default: src = 0;
            endcase
            if (tw == 1) begin
              chk("R5 oe forced off", pinOe, 0);
              chk("R5 cs follows pin", csN, v[3]);
              chk("R5 jack quiet", jackDet, 0);
              chk("R5 out quiet", pinOut, 0);
            end else if (sel < 2) begin
              chk("R4 oe off for input code", pinOe, 0);
              chk("R4 out quiet", pinOut, 0);
              chk("R4 jack sense", jackDet, (sel == 0) ? v[3] : 0);
              chk("R5 cs idle high", csN, 1);
            end else begin
              chk("R1 oe on", pinOe, expOe);
              chk("R5 cs idle high", csN, 1);
              chk("R4 jack quiet when driving", jackDet, 0);
              if (sel != 4) begin
                expOut = src ^ pol;
                if (sel >= 6)      chk("R2 constant level", pinOut, expOut);
                else if (pol == 1) chk("R3 inverted source", pinOut, expOut);
                else               chk("R1 status routed", pinOut, expOut);
              end
            end
          end

    // R6 R7: every ratio, both polarities
    for (int n = 1; n <= 4; n++) begin
      measure_ratio(n, 1'b0);
      measure_ratio(n, 1'b1);
    end

    // R8: restart on every ratio change to a ratio above one
    for (int a = 0; a < 4; a++)
      for (int b = 1; b < 4; b++)
        if (a != b) begin
          settle_drive();
          funcSel = 3'b100; polInv = 1'b0; threeWire = 1'b0; divSel = 2'(a);
          repeat (5) @(posedge pllClk);
          #3;
          divSel = 2'(b);
          @(posedge pllClk); #2;
          chk("R8 fresh high phase after ratio change", pinOut, 1);
        end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule